// File: doc/BRIEF.md
# Refresh and Low-Power Scheduler for DDR SDRAM

This block keeps a DDR SDRAM's contents alive and moves the device into and out of its two low-power states. A free-running cycle counter signals when an AUTO REFRESH is owed. The block then asks the command sequencer for the memory bus. Once the bus is granted, it closes every bank with a PRECHARGE ALL, waits the precharge time, issues the refresh, and keeps the bus through the refresh recovery window before handing it back.

User mode commands toggle the low-power states. Code 101 enters power-down, where CKE is held low and the bus shows NOPs. A second 101 leaves power-down. Code 110 enters self-refresh, and a second 110 leaves it. In power-down the block still owes refreshes: when one comes due it raises CKE, waits the exit time, runs the normal precharge and refresh sequence, and drops CKE again. In self-refresh the device refreshes itself, so the counter is frozen. While either mode is active, every other user command is dropped.

The block drives only the command pins it needs: RAS#, CAS#, WE#, A10 and CKE. Chip selects to all ranks are assumed asserted by the sequencer whenever this block owns the bus.

Top module: `rlp_scheduler`

## Requirements
- R1: After reset, CKE is high, bus_req is low, the command pins show NOP (RAS#, CAS#, WE# all 1), and both mode flags are low.
- R2: bus_req rises exactly cfg_ref_interval+1 cycles after the previous AUTO REFRESH command. The first request after reset follows the same counting from the end of reset.
- R3: When the grant is seen in cycle c, one NOP cycle follows, and PRECHARGE ALL (RAS#=0, CAS#=1, WE#=0, A10=1) appears in cycle c+2.
- R4: AUTO REFRESH (RAS#=0, CAS#=0, WE#=1, CKE=1) is issued max(cfg_trp,2) cycles after the PRECHARGE ALL.
- R5: After AUTO REFRESH only NOPs follow, and bus_req falls max(cfg_trfc,cfg_trc,2)+1 cycles after the refresh.
- R6: While a refresh is owed and the grant is withheld, bus_req stays high and no command is driven.
- R7: Command code 101 in normal mode, once the bus is granted, drops CKE with NOPs on the bus and raises in_powerdown.
- R8: In power-down, when a refresh comes due, CKE rises. PRECHARGE ALL follows max(EXIT_NOPS,2) cycles later, then the R4/R5 spacing applies. CKE then falls again while in_powerdown stays high.
- R9: A second 101 in power-down raises CKE. bus_req falls max(EXIT_NOPS,2) cycles after CKE rises, and in_powerdown drops.
- R10: Command code 110 in normal mode issues PRECHARGE ALL. max(cfg_trp,2) cycles later it issues a REFRESH with CKE low in the same cycle, and in_selfrefresh rises.
- R11: In self-refresh, CKE stays low and no command is issued for any length of time. A second 110 raises CKE, bus_req falls max(EXIT_NOPS,2) cycles later, and periodic refresh resumes.
- R12: In power-down or self-refresh, every user command other than the one that leaves the current mode is ignored, including the other mode's code.
- R13: CKE is low, or a non-NOP command is driven, only while bus_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ucmd_vld | input | 1 | User command strobe |
| ucmd | input | 3 | User command code (101 power-down toggle, 110 self-refresh toggle) |
| cfg_ref_interval | input | INTERVAL_W | Cycles between refresh requests |
| cfg_trp | input | TIME_W | Precharge period in cycles |
| cfg_trfc | input | TIME_W | Refresh recovery period in cycles |
| cfg_trc | input | TIME_W | Row cycle minimum in cycles |
| bus_gnt | input | 1 | Sequencer grants the memory bus |
| bus_req | output | 1 | Block requests or holds the memory bus |
| mem_cke | output | 1 | Clock enable to the SDRAM |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_a10 | output | 1 | Address bit 10 (all-bank select during precharge) |
| in_powerdown | output | 1 | Power-down mode active |
| in_selfrefresh | output | 1 | Self-refresh mode active |

## Verification
Every output is a decode of the state register, so results are fixed cycle offsets from their cause. The request is due interval+1 cycles after a refresh. The precharge comes two cycles after the grant. The refresh comes max(tRP,2) cycles after the precharge, and the release comes max(tRFC,tRC,2)+1 cycles after the refresh. Wake-ups put the first command or the release max(EXIT_NOPS,2) cycles after CKE rises. A monitor samples the pins on the falling clock edge and stamps each event with a cycle number. The checks then compare differences of those stamps against the offsets computed from the requirement formulas, after waiting well past the due cycle. Checks that a command is ignored count every non-NOP command across the window and read CKE and the mode flags at the pins.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

    localparam logic [2:0] UCMD_PWRDN   = 3'b101;
    localparam logic [2:0] UCMD_SELFREF = 3'b110;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ,
        S_DISP,
        S_PRE,
        S_WAIT_RP,
        S_REF,
        S_WAIT_RFC,
        S_SRE,
        S_SR,
        S_PD,
        S_WAKE
    } sched_state_e;

    typedef enum logic [1:0] {
        M_NORMAL,
        M_PD,
        M_SR
    } lp_mode_e;

    typedef enum logic [1:0] {
        G_NONE,
        G_PD,
        G_SR
    } lp_goal_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
        logic cke;
    } mem_pins_t;

    // Pin pattern driven in each scheduler state.
    function automatic mem_pins_t pins_for(input sched_state_e s);
        mem_pins_t p;
        p = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0, cke: 1'b1};
        case (s)
            S_PRE: begin
                p.ras_n = 1'b0;
                p.we_n  = 1'b0;
                p.a10   = 1'b1;
            end
            S_REF: begin
                p.ras_n = 1'b0;
                p.cas_n = 1'b0;
            end
            S_SRE: begin
                p.ras_n = 1'b0;
                p.cas_n = 1'b0;
                p.cke   = 1'b0;
            end
            S_SR, S_PD: p.cke = 1'b0;
            default: ;
        endcase
        return p;
    endfunction

    function automatic logic [15:0] max2(input logic [15:0] a, input logic [15:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rlp_interval_ctr.sv
module rlp_interval_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] limit,
    input  logic         clear,
    input  logic         hold,
    output logic         due
);
    localparam logic [W-1:0] SAT = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear || hold) begin
            cnt <= '0;
        end else if (cnt != SAT) begin
            cnt <= cnt + W'(1);
        end
    end

    // Owed once limit cycles have elapsed since the last clear.
    assign due = ((W+1)'(cnt) + (W+1)'(1)) >= (W+1)'(limit);

endmodule

// File: rtl/rlp_delay_tmr.sv
module rlp_delay_tmr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? '0 : load_val - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign done = (cnt <= W'(1));

endmodule

// File: rtl/rlp_mode_track.sv
module rlp_mode_track
    import rlp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ucmd_vld,
    input  logic [2:0] ucmd,
    input  logic       ev_pd_enter,
    input  logic       ev_sr_enter,
    input  logic       ev_pd_leave,
    output lp_mode_e   mode,
    output lp_goal_e   goal,
    output logic       leave
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= M_NORMAL;
            goal  <= G_NONE;
            leave <= 1'b0;
        end else if (ev_pd_enter) begin
            mode  <= M_PD;
            goal  <= G_NONE;
            leave <= 1'b0;
        end else if (ev_sr_enter) begin
            mode <= M_SR;
            goal <= G_NONE;
        end else if (ev_pd_leave) begin
            mode  <= M_NORMAL;
            leave <= 1'b0;
        end else if (ucmd_vld) begin
            case (mode)
                M_NORMAL: begin
                    if (goal == G_NONE) begin
                        if (ucmd == UCMD_PWRDN) begin
                            goal <= G_PD;
                        end else if (ucmd == UCMD_SELFREF) begin
                            goal <= G_SR;
                        end
                    end
                end
                M_PD: begin
                    if (ucmd == UCMD_PWRDN) begin
                        leave <= 1'b1;
                    end
                end
                M_SR: begin
                    if (ucmd == UCMD_SELFREF) begin
                        mode <= M_NORMAL;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rlp_scheduler.sv
module rlp_scheduler
    import rlp_pkg::*;
#(
    parameter int INTERVAL_W = 16,
    parameter int TIME_W     = 4,
    parameter int EXIT_NOPS  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ucmd_vld,
    input  logic [2:0]            ucmd,
    input  logic [INTERVAL_W-1:0] cfg_ref_interval,
    input  logic [TIME_W-1:0]     cfg_trp,
    input  logic [TIME_W-1:0]     cfg_trfc,
    input  logic [TIME_W-1:0]     cfg_trc,
    input  logic                  bus_gnt,
    output logic                  bus_req,
    output logic                  mem_cke,
    output logic                  mem_ras_n,
    output logic                  mem_cas_n,
    output logic                  mem_we_n,
    output logic                  mem_a10,
    output logic                  in_powerdown,
    output logic                  in_selfrefresh
);
    localparam logic [TIME_W-1:0] EXIT_V = TIME_W'(EXIT_NOPS);

    sched_state_e st, nxt;
    lp_mode_e     mode;
    lp_goal_e     goal;
    logic         leave;
    logic         due;
    logic         tmr_done;
    logic         tmr_load;
    logic [TIME_W-1:0] tmr_val;
    logic         ctr_clear;
    logic         ev_pd_enter, ev_sr_enter, ev_pd_leave;
    logic [TIME_W-1:0] rfc_wait;
    mem_pins_t    pins;

    assign rfc_wait = TIME_W'(max2(16'(cfg_trfc), 16'(cfg_trc)));

    rlp_interval_ctr #(.W(INTERVAL_W)) u_ivl (
        .clk   (clk),
        .rst   (rst),
        .limit (cfg_ref_interval),
        .clear (ctr_clear),
        .hold  (mode == M_SR),
        .due   (due)
    );

    rlp_delay_tmr #(.W(TIME_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    rlp_mode_track u_mode (
        .clk         (clk),
        .rst         (rst),
        .ucmd_vld    (ucmd_vld),
        .ucmd        (ucmd),
        .ev_pd_enter (ev_pd_enter),
        .ev_sr_enter (ev_sr_enter),
        .ev_pd_leave (ev_pd_leave),
        .mode        (mode),
        .goal        (goal),
        .leave       (leave)
    );

    always_comb begin
        nxt         = st;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        ctr_clear   = 1'b0;
        ev_pd_enter = 1'b0;
        ev_sr_enter = 1'b0;
        ev_pd_leave = 1'b0;
        case (st)
            S_IDLE: begin
                if (due || goal != G_NONE) nxt = S_REQ;
            end
            S_REQ: begin
                if (bus_gnt) nxt = S_DISP;
            end
            S_DISP: begin
                if (due) begin
                    nxt = S_PRE;
                end else if (mode == M_PD && leave) begin
                    ev_pd_leave = 1'b1;
                    nxt         = S_IDLE;
                end else if (mode == M_PD) begin
                    nxt = S_PD;
                end else if (goal == G_PD) begin
                    ev_pd_enter = 1'b1;
                    nxt         = S_PD;
                end else if (goal == G_SR) begin
                    nxt = S_PRE;
                end else begin
                    nxt = S_IDLE;
                end
            end
            S_PRE: begin
                tmr_load = 1'b1;
                tmr_val  = cfg_trp;
                nxt      = S_WAIT_RP;
            end
            S_WAIT_RP: begin
                if (tmr_done) nxt = (goal == G_SR && !due) ? S_SRE : S_REF;
            end
            S_REF: begin
                tmr_load  = 1'b1;
                tmr_val   = rfc_wait;
                ctr_clear = 1'b1;
                nxt       = S_WAIT_RFC;
            end
            S_WAIT_RFC: begin
                if (tmr_done) nxt = S_DISP;
            end
            S_SRE: begin
                ctr_clear   = 1'b1;
                ev_sr_enter = 1'b1;
                nxt         = S_SR;
            end
            S_SR: begin
                if (mode != M_SR) begin
                    tmr_load = 1'b1;
                    tmr_val  = EXIT_V;
                    nxt      = S_WAKE;
                end
            end
            S_PD: begin
                if (due || leave) begin
                    tmr_load = 1'b1;
                    tmr_val  = EXIT_V;
                    nxt      = S_WAKE;
                end
            end
            S_WAKE: begin
                if (tmr_done) nxt = S_DISP;
            end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= nxt;
    end

    assign pins           = pins_for(st);
    assign mem_cke        = pins.cke;
    assign mem_ras_n      = pins.ras_n;
    assign mem_cas_n      = pins.cas_n;
    assign mem_we_n       = pins.we_n;
    assign mem_a10        = pins.a10;
    assign bus_req        = (st != S_IDLE);
    assign in_powerdown   = (mode == M_PD);
    assign in_selfrefresh = (mode == M_SR);

endmodule

// File: rtl/rlp_checker.sv
module rlp_checker #(
    parameter int TIME_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              mem_cke,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic              mem_a10,
    input logic              in_selfrefresh,
    input logic [TIME_W-1:0] cfg_trp,
    input logic [TIME_W-1:0] cfg_trfc,
    input logic [TIME_W-1:0] cfg_trc
);
    logic       is_pre, is_ref, is_nop;
    logic [7:0] since_pre, since_ref;
    logic       pre_seen;
    logic [8:0] rfc_need;

    assign is_pre   = !mem_ras_n &&  mem_cas_n && !mem_we_n;
    assign is_ref   = !mem_ras_n && !mem_cas_n &&  mem_we_n;
    assign is_nop   =  mem_ras_n &&  mem_cas_n &&  mem_we_n;
    assign rfc_need = (cfg_trfc > cfg_trc) ? 9'(cfg_trfc) : 9'(cfg_trc);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre <= 8'hFF;
            since_ref <= 8'hFF;
            pre_seen  <= 1'b0;
        end else begin
            since_pre <= is_pre ? 8'd0 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
            since_ref <= (is_ref && mem_cke) ? 8'd0 : ((since_ref == 8'hFF) ? since_ref : since_ref + 8'd1);
            if (is_pre)      pre_seen <= 1'b1;
            else if (is_ref) pre_seen <= 1'b0;
        end
    end

    // R13: clock gating or commands only while owning the bus
    p_own_bus_r13: assert property (@(posedge clk) disable iff (rst)
        (!mem_cke || !is_nop) |-> bus_req);

    // R3: precharge always addresses all banks
    p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
        is_pre |-> mem_a10);

    // R4: every refresh follows its own precharge by at least tRP
    p_ref_after_pre_r4: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (pre_seen && (9'(since_pre) + 9'd1 >= 9'(cfg_trp))));

    // R5: bus released no earlier than refresh recovery
    p_release_late_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> (9'(since_ref) + 9'd1 >= rfc_need));

    // R10: refresh with CKE low enters self-refresh
    p_sr_entry_r10: assert property (@(posedge clk) disable iff (rst)
        (is_ref && !mem_cke) |=> in_selfrefresh);

    // R11: quiet bus and CKE low throughout self-refresh
    p_sr_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (in_selfrefresh && $past(in_selfrefresh)) |-> (is_nop && !mem_cke));

endmodule

bind rlp_scheduler rlp_checker #(.TIME_W(TIME_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_req        (bus_req),
    .mem_cke        (mem_cke),
    .mem_ras_n      (mem_ras_n),
    .mem_cas_n      (mem_cas_n),
    .mem_we_n       (mem_we_n),
    .mem_a10        (mem_a10),
    .in_selfrefresh (in_selfrefresh),
    .cfg_trp        (cfg_trp),
    .cfg_trfc       (cfg_trfc),
    .cfg_trc        (cfg_trc)
);

// File: tb/sim_rlp_scheduler.sv
module sim_rlp_scheduler;
    localparam int CLK_PERIOD = 10;
    localparam int EXIT_N     = 2;
    localparam int EXIT_EFF   = (EXIT_N > 2) ? EXIT_N : 2;

    // interval, trp, trfc, trc, exp pre->ref, exp ref->release, exp period
    localparam int VEC [4][7] = '{
        '{40, 2,  9, 8, 2, 10, 45},
        '{30, 3,  4, 7, 3,  8, 36},
        '{50, 1,  2, 3, 2,  4, 55},
        '{25, 5, 12, 6, 5, 13, 33}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ucmd_vld = 1'b0;
    logic [2:0]  ucmd = 3'b000;
    logic [15:0] cfg_ref_interval = 16'd40;
    logic [3:0]  cfg_trp = 4'd2, cfg_trfc = 4'd9, cfg_trc = 4'd8;
    logic        allow = 1'b1;
    logic        bus_gnt;
    logic        bus_req, mem_cke, mem_ras_n, mem_cas_n, mem_we_n, mem_a10;
    logic        in_powerdown, in_selfrefresh;

    int nchk = 0, nerr = 0;
    int cyc = 0;
    int ref_cnt, pre_cnt, sre_cnt, rise_cnt, fall_cnt, cmd_total;
    int last_ref, prev_ref, last_pre, last_a10, last_sre, last_req_rise, last_fall, last_cke_rise;
    logic p_req, p_cke;
    bit   finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign bus_gnt = bus_req & allow;

    rlp_scheduler #(.INTERVAL_W(16), .TIME_W(4), .EXIT_NOPS(EXIT_N)) u0 (
        .clk(clk), .rst(rst), .ucmd_vld(ucmd_vld), .ucmd(ucmd),
        .cfg_ref_interval(cfg_ref_interval), .cfg_trp(cfg_trp),
        .cfg_trfc(cfg_trfc), .cfg_trc(cfg_trc), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .mem_cke(mem_cke), .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_a10(mem_a10),
        .in_powerdown(in_powerdown), .in_selfrefresh(in_selfrefresh)
    );

    // Pin monitor: stamps events with a cycle number on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            ref_cnt = 0; pre_cnt = 0; sre_cnt = 0; rise_cnt = 0; fall_cnt = 0; cmd_total = 0;
            last_ref = 0; prev_ref = 0; last_pre = 0; last_a10 = 0; last_sre = 0;
            last_req_rise = 0; last_fall = 0; last_cke_rise = 0;
            p_req = 1'b0; p_cke = 1'b1;
        end else begin
            if (!mem_ras_n && mem_cas_n && !mem_we_n) begin
                pre_cnt++; last_pre = cyc; last_a10 = int'(mem_a10);
            end
            if (!mem_ras_n && !mem_cas_n && mem_we_n) begin
                if (mem_cke) begin prev_ref = last_ref; last_ref = cyc; ref_cnt++; end
                else begin sre_cnt++; last_sre = cyc; end
            end
            if (!(mem_ras_n && mem_cas_n && mem_we_n)) cmd_total++;
            if (bus_req && !p_req) last_req_rise = cyc;
            if (!bus_req && p_req) begin last_fall = cyc; fall_cnt++; end
            if (mem_cke && !p_cke) begin last_cke_rise = cyc; rise_cnt++; end
            p_req = bus_req;
            p_cke = mem_cke;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic [2:0] c);
        @(negedge clk);
        ucmd_vld = 1'b1;
        ucmd     = c;
        @(negedge clk);
        ucmd_vld = 1'b0;
        ucmd     = 3'b000;
    endtask

    task automatic wait_cnt(ref int cnt, input int target, input int limit);
        for (int i = 0; i < limit && cnt < target; i++) @(posedge clk);
    endtask

    initial begin
        int base;
        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1 reset pins {cke,req,ras,cas,we,pd,sr}",
            int'({mem_cke, bus_req, mem_ras_n, mem_cas_n, mem_we_n, in_powerdown, in_selfrefresh}),
            int'(7'b1011100));

        // Vector table: refresh cadence and spacing (R2, R3, R4, R5)
        for (int v = 0; v < 4; v++) begin
            cfg_ref_interval = 16'(VEC[v][0]);
            cfg_trp  = 4'(VEC[v][1]);
            cfg_trfc = 4'(VEC[v][2]);
            cfg_trc  = 4'(VEC[v][3]);
            allow = 1'b1;
            do_reset();
            wait_cnt(ref_cnt, 2, 400);
            repeat (20) @(posedge clk);
            chk("R2 refresh period", last_ref - prev_ref, VEC[v][6]);
            chk("R2 request after refresh", last_req_rise - prev_ref, VEC[v][0] + 1);
            chk("R3 grant to precharge", last_pre - last_req_rise, 2);
            chk("R3 precharge A10", last_a10, 1);
            chk("R4 precharge to refresh", last_ref - last_pre, VEC[v][4]);
            chk("R5 refresh to release", last_fall - last_ref, VEC[v][5]);
        end

        // R6: grant withheld
        cfg_ref_interval = 16'd40; cfg_trp = 4'd2; cfg_trfc = 4'd9; cfg_trc = 4'd8;
        allow = 1'b0;
        do_reset();
        for (int i = 0; i < 200 && !bus_req; i++) @(negedge clk);
        @(posedge clk);
        base = cmd_total;
        repeat (30) @(posedge clk);
        chk("R6 no command without grant", cmd_total - base, 0);
        @(negedge clk);
        chk("R6 request held", int'(bus_req), 1);
        allow = 1'b1;
        repeat (5) @(posedge clk);
        chk("R6 pending refresh proceeds", pre_cnt, 1);

        // Power-down: R7, R8, R9, R12
        cfg_ref_interval = 16'd60;
        do_reset();
        send(3'b101);
        for (int i = 0; i < 50 && !in_powerdown; i++) @(negedge clk);
        @(negedge clk);
        chk("R7 power-down {pd,cke,req}", int'({in_powerdown, mem_cke, bus_req}), int'(3'b101));
        @(posedge clk);
        base = cmd_total;
        send(3'b001);
        send(3'b110);
        @(negedge clk);
        chk("R12 power-down ignores {sr,cke}", int'({in_selfrefresh, mem_cke}), 0);
        @(posedge clk);
        chk("R12 no command in power-down", cmd_total - base, 0);
        wait_cnt(rise_cnt, 1, 200);
        wait_cnt(ref_cnt, 1, 40);
        chk("R8 wake to precharge", last_pre - last_cke_rise, EXIT_EFF);
        repeat (15) @(posedge clk);
        @(negedge clk);
        chk("R8 back in power-down {pd,cke}", int'({in_powerdown, mem_cke}), int'(2'b10));
        send(3'b101);
        wait_cnt(fall_cnt, 1, 50);
        repeat (2) @(posedge clk);
        chk("R9 exit to release", last_fall - last_cke_rise, EXIT_EFF);
        @(negedge clk);
        chk("R9 power-down flag cleared", int'(in_powerdown), 0);

        // Self-refresh: R10, R11, R12
        cfg_ref_interval = 16'd40;
        do_reset();
        send(3'b110);
        wait_cnt(sre_cnt, 1, 50);
        chk("R10 precharge to self-refresh entry", last_sre - last_pre, 2);
        @(negedge clk);
        chk("R10 self-refresh {sr,cke}", int'({in_selfrefresh, mem_cke}), int'(2'b10));
        @(posedge clk);
        base = cmd_total;
        repeat (150) @(posedge clk);
        chk("R11 no command in self-refresh", cmd_total - base, 0);
        send(3'b101);
        send(3'b001);
        @(negedge clk);
        chk("R12 self-refresh ignores {pd,cke}", int'({in_powerdown, mem_cke}), 0);
        send(3'b110);
        wait_cnt(fall_cnt, 1, 50);
        repeat (2) @(posedge clk);
        chk("R11 exit to release", last_fall - last_cke_rise, EXIT_EFF);
        @(negedge clk);
        chk("R11 self-refresh flag cleared", int'(in_selfrefresh), 0);
        @(posedge clk);
        wait_cnt(ref_cnt, 1, 100);
        chk("R11 periodic refresh resumes", int'(ref_cnt >= 1), 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule